// File: doc/BRIEF.md
# Power-Good Deglitch and Timeout Monitor

This block watches the undervoltage comparator flags of several regulator outputs. It turns them into one active-high power-good pin, a per-regulator status vector and a timeout-fault request for a reset controller. Each regulator has its own filter. A low flag counts only after it has been held without a break for longer than the qualify time (25 µs by default). Once it counts, the block reports that regulator as bad until the flag clears and a further stretch time (250 µs by default) has passed. Time is measured with a prescaler that makes microsecond and millisecond ticks from a clock of known frequency.

The power-good pin goes low when any enabled regulator is reported bad. It also goes low while an enabled regulator is in a dynamic voltage slew, unless that regulator's slew-mask bit is set. Slews never touch the status vector. If power-good stays low for longer than the timeout (14 ms by default), the block issues a one-cycle fault pulse and sets a sticky fault flag. The global timeout-mask bit suppresses both. A synchronous reset clears the sticky flag.

Each regulator filter is a state machine with five states. CH_OFF holds while the regulator is disabled. From CH_OFF the filter enters CH_GOOD once the regulator is enabled. A low flag moves CH_GOOD to CH_QUAL. The filter falls back from CH_QUAL to CH_GOOD if the flag drops, and goes on to CH_LOW once the qualify time expires. When the flag clears, CH_LOW moves to CH_HOLD. CH_HOLD returns to CH_LOW on a new low flag, or to CH_GOOD once the stretch time expires. Disabling the regulator forces CH_OFF from any state. The timeout machine has three states. TO_IDLE moves to TO_COUNT when power-good falls. TO_COUNT returns to TO_IDLE when power-good rises, and moves to TO_FIRED on expiry. TO_FIRED returns to TO_IDLE when power-good rises.

Top module: `pg_monitor`

## Requirements
- R1: After reset, pwr_ok is 1, every pg_status bit is 1, to_fault_pulse is 0 and to_fault_sticky is 0.
- R2: A low flag on an enabled regulator that lasts less than the qualify time (20 µs or shorter at the defaults) changes neither pg_status nor pwr_ok.
- R3: A low flag held without a break for more than the qualify time clears that regulator's pg_status bit and drives pwr_ok to 0. The change occurs between 25 and 27 µs after the flag rises.
- R4: After the low flag clears, the pg_status bit and pwr_ok stay 0 for the stretch time and recover between 250 and 253 µs after the release.
- R5: A new low flag during the stretch returns the regulator to the low state at once. The stretch then starts again from the next release.
- R6: A disabled regulator reads 1 in pg_status. Its low and slew flags have no effect on pwr_ok, and disabling a regulator that is low restores its status bit on the next cycle.
- R7: While an enabled regulator has slew_act at 1 and slew_mask at 0, pwr_ok is 0 from the next cycle on. With slew_mask at 1 the slew has no effect, and pg_status never reacts to slews.
- R8: When pwr_ok stays 0 for more than the timeout (fault between 14 and 15.1 ms), to_fault_pulse is 1 for exactly one cycle, once per low episode, and to_fault_sticky is set.
- R9: With to_mask at 1, no fault pulse is raised and the sticky flag does not change. pwr_ok still follows its normal rules.
- R10: to_fault_sticky, once set, stays 1 until rst_n is asserted, even after pwr_ok recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; CYC_PER_US cycles make one microsecond |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_en | input | NUM_REG | Regulator enable bits |
| reg_low | input | NUM_REG | Undervoltage comparator flags, 1 = low |
| slew_act | input | NUM_REG | Dynamic slew in progress per regulator |
| slew_mask | input | NUM_REG | 1 = slew does not pull pwr_ok low |
| to_mask | input | 1 | 1 = suppress the timeout fault |
| pwr_ok | output | 1 | Power-good pin, 1 = good (registered) |
| pg_status | output | NUM_REG | Filtered per-regulator status, 1 = good |
| to_fault_pulse | output | 1 | One-cycle timeout fault request |
| to_fault_sticky | output | 1 | Sticky timeout fault flag |

## Verification
A filter stuck in the wrong state shows at pg_status within one cycle. It reaches pwr_ok one cycle after that. A count that is off shifts the qualify or stretch edges by whole microseconds, so the bench brackets each edge with one sample just before the edge and one just after it. A fault in the timeout machine shows as a pulse that is missing, repeated or mistimed within one millisecond of the 14 ms limit, or as a sticky flag that misbehaves. Random slews on masked and disabled channels, and glitches shorter than the qualify time, show whether any unwanted path reaches the pin.

// File: rtl/pg_mon_pkg.sv
package pg_mon_pkg;
    typedef enum logic [2:0] {
        CH_OFF,
        CH_GOOD,
        CH_QUAL,
        CH_LOW,
        CH_HOLD
    } chan_state_e;

    typedef enum logic [1:0] {
        TO_IDLE,
        TO_COUNT,
        TO_FIRED
    } tmo_state_e;
endpackage

// File: rtl/pg_tick.sv
module pg_tick #(
    parameter int CYC_PER_US = 100,
    parameter int US_PER_MS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic us_tick,
    output logic ms_tick
);
    localparam int UW = $clog2(CYC_PER_US + 1);
    localparam int MW = $clog2(US_PER_MS + 1);

    logic [UW-1:0] cyc_q;
    logic [MW-1:0] us_q;

    assign us_tick = (cyc_q == UW'(CYC_PER_US - 1));
    assign ms_tick = us_tick && (us_q == MW'(US_PER_MS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            us_q  <= '0;
        end else begin
            cyc_q <= us_tick ? '0 : cyc_q + UW'(1);
            if (us_tick) begin
                us_q <= ms_tick ? '0 : us_q + MW'(1);
            end
        end
    end
endmodule

// File: rtl/pg_chan.sv
module pg_chan
    import pg_mon_pkg::*;
#(
    parameter int QUAL_US = 25,
    parameter int HOLD_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic en,
    input  logic low,
    output logic bad
);
    localparam int LIM = (QUAL_US > HOLD_US) ? QUAL_US : HOLD_US;
    localparam int CW  = $clog2(LIM + 1);

    chan_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en) begin
            st_d  = CH_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                CH_OFF:  st_d = CH_GOOD;
                CH_GOOD: begin
                    if (low) begin
                        st_d  = CH_QUAL;
                        cnt_d = '0;
                    end
                end
                CH_QUAL: begin
                    if (!low) begin
                        st_d = CH_GOOD;
                    end else if (us_tick) begin
                        if (cnt_q >= CW'(QUAL_US)) st_d = CH_LOW;
                        else                       cnt_d = cnt_q + CW'(1);
                    end
                end
                CH_LOW: begin
                    if (!low) begin
                        st_d  = CH_HOLD;
                        cnt_d = '0;
                    end
                end
                CH_HOLD: begin
                    if (low) begin
                        st_d = CH_LOW;
                    end else if (us_tick) begin
                        if (cnt_q >= CW'(HOLD_US)) st_d = CH_GOOD;
                        else                       cnt_d = cnt_q + CW'(1);
                    end
                end
                default: st_d = CH_OFF;
            endcase
        end
    end

    always_comb begin
        bad = (st_q == CH_LOW) || (st_q == CH_HOLD);
    end
endmodule

// File: rtl/pg_timeout.sv
module pg_timeout
    import pg_mon_pkg::*;
#(
    parameter int TIMEOUT_MS = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic pg_low,
    input  logic mask,
    output logic pulse,
    output logic sticky
);
    localparam int CW = $clog2(TIMEOUT_MS + 1);

    tmo_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic fire_d, pulse_q, sticky_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= TO_IDLE;
            cnt_q    <= '0;
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            pulse_q  <= fire_d;
            sticky_q <= sticky_q | fire_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        fire_d = 1'b0;
        unique case (st_q)
            TO_IDLE: begin
                if (pg_low) begin
                    st_d  = TO_COUNT;
                    cnt_d = '0;
                end
            end
            TO_COUNT: begin
                if (!pg_low) begin
                    st_d = TO_IDLE;
                end else if (ms_tick) begin
                    if (cnt_q >= CW'(TIMEOUT_MS)) begin
                        st_d   = TO_FIRED;
                        fire_d = !mask;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            TO_FIRED: begin
                if (!pg_low) st_d = TO_IDLE;
            end
            default: st_d = TO_IDLE;
        endcase
    end

    always_comb begin
        pulse  = pulse_q;
        sticky = sticky_q;
    end
endmodule

// File: rtl/pg_monitor.sv
module pg_monitor #(
    parameter int NUM_REG    = 4,
    parameter int CYC_PER_US = 100,
    parameter int US_PER_MS  = 1000,
    parameter int QUAL_US    = 25,
    parameter int HOLD_US    = 250,
    parameter int TIMEOUT_MS = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REG-1:0] reg_en,
    input  logic [NUM_REG-1:0] reg_low,
    input  logic [NUM_REG-1:0] slew_act,
    input  logic [NUM_REG-1:0] slew_mask,
    input  logic               to_mask,
    output logic               pwr_ok,
    output logic [NUM_REG-1:0] pg_status,
    output logic               to_fault_pulse,
    output logic               to_fault_sticky
);
    logic us_tick, ms_tick;
    logic [NUM_REG-1:0] bad;
    logic [NUM_REG-1:0] slew_hit;
    logic pwr_ok_q;

    pg_tick #(
        .CYC_PER_US(CYC_PER_US),
        .US_PER_MS (US_PER_MS)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .us_tick(us_tick),
        .ms_tick(ms_tick)
    );

    for (genvar i = 0; i < NUM_REG; i++) begin : g_chan
        pg_chan #(
            .QUAL_US(QUAL_US),
            .HOLD_US(HOLD_US)
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .us_tick(us_tick),
            .en     (reg_en[i]),
            .low    (reg_low[i]),
            .bad    (bad[i])
        );
    end

    assign slew_hit = slew_act & ~slew_mask & reg_en;

    always_ff @(posedge clk) begin
        if (!rst_n) pwr_ok_q <= 1'b1;
        else        pwr_ok_q <= !((|bad) || (|slew_hit));
    end

    pg_timeout #(
        .TIMEOUT_MS(TIMEOUT_MS)
    ) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_tick(ms_tick),
        .pg_low (!pwr_ok_q),
        .mask   (to_mask),
        .pulse  (to_fault_pulse),
        .sticky (to_fault_sticky)
    );

    assign pwr_ok    = pwr_ok_q;
    assign pg_status = ~bad;
endmodule

// File: rtl/pg_monitor_chk.sv
module pg_monitor_chk #(
    parameter int NUM_REG = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REG-1:0] reg_en,
    input logic [NUM_REG-1:0] reg_low,
    input logic               to_mask,
    input logic               pwr_ok,
    input logic [NUM_REG-1:0] pg_status,
    input logic               to_fault_pulse,
    input logic               to_fault_sticky
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        to_fault_pulse |=> !to_fault_pulse); // R8

    AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        to_fault_pulse |=> to_fault_sticky); // R8

    AST_PULSE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        to_fault_pulse |-> !$past(pwr_ok)); // R8

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        to_fault_sticky |=> to_fault_sticky); // R10

    AST_MASK_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        to_mask |=> !to_fault_pulse); // R9

    for (genvar i = 0; i < NUM_REG; i++) begin : g_chk
        AST_DISABLED_READS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_en[i] |=> pg_status[i]); // R6

        AST_BAD_PULLS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            !pg_status[i] |=> !pwr_ok); // R3

        AST_FALL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pg_status[i]) |-> $past(reg_low[i])); // R2
    end
endmodule

bind pg_monitor pg_monitor_chk #(
    .NUM_REG(NUM_REG)
) u_pg_monitor_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_en         (reg_en),
    .reg_low        (reg_low),
    .to_mask        (to_mask),
    .pwr_ok         (pwr_ok),
    .pg_status      (pg_status),
    .to_fault_pulse (to_fault_pulse),
    .to_fault_sticky(to_fault_sticky)
);

// File: tb/pg_monitor_bench.sv
`timescale 1ns/1ps
module pg_monitor_bench;
    localparam int N   = 4;
    localparam int CPU = 2;     // cycles per microsecond in the bench
    localparam int UPM = 1000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] reg_en = '0;
    logic [N-1:0] reg_low = '0;
    logic [N-1:0] slew_act = '0;
    logic [N-1:0] slew_mask = '0;
    logic         to_mask = 1'b0;
    logic         pwr_ok;
    logic [N-1:0] pg_status;
    logic         to_fault_pulse;
    logic         to_fault_sticky;

    int n_chk  = 0;
    int n_fail = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    pg_monitor #(
        .NUM_REG(N), .CYC_PER_US(CPU), .US_PER_MS(UPM),
        .QUAL_US(25), .HOLD_US(250), .TIMEOUT_MS(14)
    ) u_pg_monitor (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_low(reg_low),
        .slew_act(slew_act), .slew_mask(slew_mask), .to_mask(to_mask),
        .pwr_ok(pwr_ok), .pg_status(pg_status),
        .to_fault_pulse(to_fault_pulse), .to_fault_sticky(to_fault_sticky)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_pin(input logic [N-1:0] en, input logic [N-1:0] sl,
                                     input logic [N-1:0] mk);
        return !(|(en & sl & ~mk));
    endfunction

    // advance n cycles, counting fault pulses seen at each sample point
    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (to_fault_pulse) pulses++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] e, s, m;
        int ok_all;
        int elapsed;
        int seen;
        void'($urandom(32'd1234));
        do_reset();
        step(1);
        // R1 reset state
        chk(pwr_ok == 1'b1, "R1", "pwr_ok", pwr_ok, 1);
        chk(pg_status == '1, "R1", "pg_status", pg_status, 15);
        chk(to_fault_pulse == 1'b0, "R1", "pulse", to_fault_pulse, 0);
        chk(to_fault_sticky == 1'b0, "R1", "sticky", to_fault_sticky, 0);
        reg_en = '1;
        step(4);

        // R2 random short glitches
        ok_all = 1;
        for (int it = 0; it < 20; it++) begin
            int ch = $urandom_range(N - 1, 0);
            int w  = $urandom_range(20, 1);
            reg_low[ch] = 1'b1;
            for (int c = 0; c < w * CPU; c++) begin
                step(1);
                if (!pwr_ok || pg_status != '1) ok_all = 0;
            end
            reg_low[ch] = 1'b0;
            for (int c = 0; c < $urandom_range(10, 2) * CPU; c++) begin
                step(1);
                if (!pwr_ok || pg_status != '1) ok_all = 0;
            end
        end
        chk(ok_all == 1, "R2", "short glitches ignored", ok_all, 1);

        // R3 qualify edge
        reg_low[1] = 1'b1;
        step(24 * CPU);
        chk(pg_status[1] == 1'b1, "R3", "status before 25us", pg_status[1], 1);
        step(4 * CPU);
        chk(pg_status[1] == 1'b0, "R3", "status after 28us", pg_status[1], 0);
        chk(pwr_ok == 1'b0, "R3", "pwr_ok after 28us", pwr_ok, 0);
        chk(pg_status[0] == 1'b1, "R3", "other channel", pg_status[0], 1);

        // R4 stretch
        step(20 * CPU);
        reg_low[1] = 1'b0;
        step(248 * CPU);
        chk(pg_status[1] == 1'b0, "R4", "status at 248us", pg_status[1], 0);
        chk(pwr_ok == 1'b0, "R4", "pwr_ok at 248us", pwr_ok, 0);
        step(6 * CPU);
        chk(pg_status[1] == 1'b1, "R4", "status at 254us", pg_status[1], 1);
        chk(pwr_ok == 1'b1, "R4", "pwr_ok at 254us", pwr_ok, 1);

        // R5 restart of stretch
        reg_low[2] = 1'b1;
        step(30 * CPU);
        reg_low[2] = 1'b0;
        step(100 * CPU);
        reg_low[2] = 1'b1;
        step(5 * CPU);
        chk(pg_status[2] == 1'b0, "R5", "re-low status", pg_status[2], 0);
        reg_low[2] = 1'b0;
        step(248 * CPU);
        chk(pg_status[2] == 1'b0, "R5", "status 248us after 2nd release", pg_status[2], 0);
        step(6 * CPU);
        chk(pg_status[2] == 1'b1, "R5", "status 254us after 2nd release", pg_status[2], 1);

        // R6 disabled channel ignored
        reg_en[2] = 1'b0;
        reg_low[2] = 1'b1;
        slew_act[2] = 1'b1;
        step(60 * CPU);
        chk(pg_status[2] == 1'b1, "R6", "disabled status", pg_status[2], 1);
        chk(pwr_ok == 1'b1, "R6", "disabled pin", pwr_ok, 1);
        reg_low[2] = 1'b0;
        slew_act[2] = 1'b0;
        reg_en[2] = 1'b1;
        reg_low[3] = 1'b1;
        step(30 * CPU);
        chk(pg_status[3] == 1'b0, "R6", "ch3 low before disable", pg_status[3], 0);
        reg_en[3] = 1'b0;
        step(1);
        chk(pg_status[3] == 1'b1, "R6", "status after disable", pg_status[3], 1);
        step(1);
        chk(pwr_ok == 1'b1, "R6", "pin after disable", pwr_ok, 1);
        reg_low[3] = 1'b0;
        reg_en[3] = 1'b1;
        step(4);

        // R7 directed and random slews
        slew_act[0] = 1'b1;
        step(1);
        chk(pwr_ok == 1'b0, "R7", "unmasked slew", pwr_ok, 0);
        chk(pg_status == '1, "R7", "status during slew", pg_status, 15);
        slew_mask[0] = 1'b1;
        step(2);
        chk(pwr_ok == 1'b1, "R7", "masked slew", pwr_ok, 1);
        for (int it = 0; it < 30; it++) begin
            e = N'($urandom); s = N'($urandom); m = N'($urandom);
            reg_en = e; slew_act = s; slew_mask = m;
            step(2);
            chk(pwr_ok == exp_pin(e, s, m), "R7", "random slew pin", pwr_ok, exp_pin(e, s, m));
            chk(pg_status == '1, "R7", "random slew status", pg_status, 15);
        end
        reg_en = '1; slew_act = '0; slew_mask = '0;
        step(4);

        // R9 masked timeout
        to_mask = 1'b1;
        pulses = 0;
        slew_act[0] = 1'b1;
        step(16 * UPM * CPU);
        chk(pulses == 0, "R9", "pulses while masked", pulses, 0);
        chk(to_fault_sticky == 1'b0, "R9", "sticky while masked", to_fault_sticky, 0);
        chk(pwr_ok == 1'b0, "R9", "pin still low", pwr_ok, 0);
        slew_act[0] = 1'b0;
        step(3);
        chk(pwr_ok == 1'b1, "R9", "pin recovers", pwr_ok, 1);
        to_mask = 1'b0;
        step(2);

        // R8 timeout fault
        slew_act[0] = 1'b1;
        elapsed = 0;
        seen = 0;
        while (!seen && elapsed < 32000) begin
            @(negedge clk);
            elapsed++;
            if (to_fault_pulse) seen = 1;
        end
        chk(seen == 1, "R8", "pulse raised", seen, 1);
        chk(elapsed >= 14 * UPM * CPU, "R8", "not before 14ms (cycles)", elapsed, 14 * UPM * CPU);
        chk(elapsed <= 15100 * CPU, "R8", "by 15.1ms (cycles)", elapsed, 15100 * CPU);
        pulses = 0;
        step(1);
        chk(to_fault_pulse == 1'b0, "R8", "pulse width", to_fault_pulse, 0);
        chk(to_fault_sticky == 1'b1, "R8", "sticky set", to_fault_sticky, 1);
        step(4 * UPM * CPU);
        chk(pulses == 0, "R8", "single pulse per episode", pulses, 0);

        // R10 sticky holds until reset
        slew_act[0] = 1'b0;
        step(10);
        chk(pwr_ok == 1'b1, "R10", "pin recovered", pwr_ok, 1);
        chk(to_fault_sticky == 1'b1, "R10", "sticky holds", to_fault_sticky, 1);
        do_reset();
        step(1);
        chk(to_fault_sticky == 1'b0, "R10", "sticky cleared by reset", to_fault_sticky, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule